// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Break Generation

This block turns parallel characters into an asynchronous serial stream. A writer places a character in a one-entry holding register. On the next bit-period boundary when the shifter is free, the character moves into a separate shift register. This frees the holding register for the next character while the current one is still on the line, so frames can run back to back with no gap. Each frame is a low start bit, then 8 data bits least significant bit first, then an optional ninth bit, then a high stop bit. Parity, where used, is computed by the writer and carried in the ninth bit.

Two flags report progress. The empty flag says the holding register can take another character. The complete flag says the line has finished its last stop bit and nothing is waiting. A break control replaces frames with all-zero characters. A transmit enable gates the whole block. When the enable rises, one idle character of 1s is sent before any queued frame. The bit-rate tick comes from an external generator: a one-cycle pulse once per bit period.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, the line output is 1, the empty flag is 1 and the complete flag is 1.
- R2: Each character is a 0 start bit, data bits 0 to 7 in that order, and a 1 stop bit. The line changes only in the cycle after a bit tick, so each bit lasts exactly one tick interval.
- R3: When the nine-bit mode input is 1 at the tick that loads a frame, the ninth-bit input is sent between data bit 7 and the stop bit, giving an 11-bit frame. Otherwise the frame has 10 bits.
- R4: A write made while the empty flag is 1 stores the data and clears both the empty flag and the complete flag in the next cycle. The empty flag returns to 1 in the cycle after the tick that moves the character into the shifter.
- R5: A write made while the empty flag is 0 is ignored. The stored character and the frames sent afterwards are unchanged.
- R6: The complete flag rises in the cycle after the first tick that ends a stop bit (or idle bit) while the holding register is empty. While characters stay queued, frames follow with no idle bit between them and the complete flag stays 0.
- R7: While enabled with nothing to send, the line is 1.
- R8: While the enable is 0, the line is 1, no bits are sent, any frame in progress is dropped, and a written character is held until the enable returns.
- R9: After the enable goes from 0 to 1, one idle character of 1s (10 or 11 bits, following the mode) is sent before the first frame.
- R10: While break is 1 at a character boundary, all-zero characters of frame length are sent, one after another.
- R11: When break is cleared, exactly one 1 bit follows the last break character before the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse once per bit period |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 1 selects 11-bit frames with a ninth data bit |
| ninth_bit | input | 1 | Value of the ninth data bit |
| brk | input | 1 | Send break characters while 1 |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| txd | output | 1 | Serial line output, idle high |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
All three outputs are registered, so each result is due exactly one cycle after the clock edge that samples its cause. The line and the empty flag move in the cycle after a bit tick. Both flags react to a write in the cycle after the write strobe. The bench drives inputs and compares outputs on falling edges. Its behavioural model advances on the same rising edge as the design, so every cycle is compared at the point where the new value has settled. The model holds a queue of pending line bits, and the tests place writes, mode changes, break and enable changes at varied offsets from the tick.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    // Source of the bits loaded into the shifter at a character boundary.
    typedef enum logic [2:0] {
        SRC_NONE     = 3'd0,
        SRC_PREAMBLE = 3'd1,
        SRC_BREAK    = 3'd2,
        SRC_GAP      = 3'd3,
        SRC_DATA     = 3'd4
    } load_src_e;
endpackage

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end else if (wr_stb && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full = hold_q.full;
    assign data = hold_q.data;

    assert_write_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !full) |=> full);
    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && full && !take) |=> $stable(data));
    assert_take_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
    assert_take_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !full);
endmodule

// File: rtl/serial_tx_frame.sv
module serial_tx_frame #(
    parameter int DATA_W = 8,
    localparam int FW = DATA_W + 3,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              nine_bit,
    input  logic              ninth_bit,
    output logic [FW-1:0]     frame,
    output logic [CW-1:0]     frame_len
);
    // Bit 0 leaves first: start, data LSB first, optional ninth, stop.
    always_comb begin
        frame              = '1;
        frame[0]           = 1'b0;
        frame[DATA_W:1]    = data;
        frame[DATA_W+1]    = nine_bit ? ninth_bit : 1'b1;
        frame_len          = nine_bit ? CW'(FW) : CW'(FW - 1);
    end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int FW = DATA_W + 3,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          tx_en,
    input  logic          brk,
    input  logic          hold_full,
    input  logic [FW-1:0] frame,
    input  logic [CW-1:0] frame_len,
    output logic          txd,
    output logic          take,
    output logic          idle_tick
);
    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          txd;
        logic          pend;
        logic          post_brk;
    } shift_t;

    shift_t    sh_d, sh_q;
    load_src_e src;
    logic      free;
    logic [FW-1:0] vec;
    logic [CW-1:0] len;

    assign free = (sh_q.cnt == '0);

    // Pick what to load at a character boundary, in priority order.
    always_comb begin
        src = SRC_NONE;
        if (tx_en && bit_tick && free) begin
            if (sh_q.pend)           src = SRC_PREAMBLE;
            else if (brk)            src = SRC_BREAK;
            else if (sh_q.post_brk)  src = SRC_GAP;
            else if (hold_full)      src = SRC_DATA;
        end
    end

    always_comb begin
        sh_d      = sh_q;
        take      = 1'b0;
        idle_tick = 1'b0;
        vec       = '1;
        len       = '0;
        unique case (src)
            SRC_PREAMBLE: begin vec = '1;    len = frame_len; end
            SRC_BREAK:    begin vec = '0;    len = frame_len; end
            SRC_GAP:      begin vec = '1;    len = CW'(1);    end
            SRC_DATA:     begin vec = frame; len = frame_len; end
            default:      begin vec = '1;    len = '0;        end
        endcase

        if (!tx_en) begin
            sh_d.sh       = '1;
            sh_d.cnt      = '0;
            sh_d.txd      = 1'b1;
            sh_d.pend     = 1'b1;
            sh_d.post_brk = 1'b0;
        end else if (bit_tick) begin
            if (free) begin
                if (src == SRC_PREAMBLE) sh_d.pend     = 1'b0;
                if (src == SRC_BREAK)    sh_d.post_brk = 1'b1;
                if (src == SRC_GAP)      sh_d.post_brk = 1'b0;
                if (src == SRC_DATA)     take          = 1'b1;
                if (src == SRC_NONE) begin
                    idle_tick = 1'b1;
                    sh_d.txd  = 1'b1;
                end else begin
                    sh_d.txd = vec[0];
                    sh_d.sh  = vec >> 1;
                    sh_d.cnt = len - CW'(1);
                end
            end else begin
                sh_d.txd = sh_q.sh[0];
                sh_d.sh  = sh_q.sh >> 1;
                sh_d.cnt = sh_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{sh: '1, cnt: '0, txd: 1'b1, pend: 1'b1, post_brk: 1'b0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd = sh_q.txd;

    assert_line_high_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);
    assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(txd));
    assert_break_drives_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && brk) |-> 1'b0 == (take && brk));
    assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take, idle_tick}));
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
    parameter int DATA_W = 8,
    localparam int FW = DATA_W + 3,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              ninth_bit,
    input  logic              brk,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tdre,
    output logic              tc
);
    typedef struct packed {
        logic tc;
    } top_t;

    top_t top_d, top_q;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              idle_tick;
    logic [FW-1:0]     frame;
    logic [CW-1:0]     frame_len;

    serial_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    serial_tx_frame #(.DATA_W(DATA_W)) u_frame (
        .data      (hold_data),
        .nine_bit  (nine_bit),
        .ninth_bit (ninth_bit),
        .frame     (frame),
        .frame_len (frame_len)
    );

    serial_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .brk       (brk),
        .hold_full (hold_full),
        .frame     (frame),
        .frame_len (frame_len),
        .txd       (txd),
        .take      (take),
        .idle_tick (idle_tick)
    );

    always_comb begin
        top_d = top_q;
        if (wr_stb && !hold_full) top_d.tc = 1'b0;
        else if (idle_tick)       top_d.tc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{tc: 1'b1};
        end else begin
            top_q <= top_d;
        end
    end

    assign tdre = !hold_full;
    assign tc   = top_q.tc;

    assert_complete_implies_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> tdre);
    assert_write_clears_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tdre) |=> !tc);
    assert_complete_rises_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> txd);
endmodule

// File: tb/tb_serial_tx_dbuf.sv
module tb_serial_tx_dbuf;
    localparam int TICKP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       brk = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tdre, tc;

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    int    tick_cnt = 0;
    bit    run_cmp = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    serial_tx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .nine_bit(nine_bit), .ninth_bit(ninth_bit), .brk(brk),
        .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .tdre(tdre), .tc(tc)
    );

    always #10 clk = ~clk;

    // Reference model: a queue of line bits still to be sent.
    bit       line_fifo[$];
    bit       m_txd = 1, m_tdre = 1, m_tc = 1, m_pend = 1, m_post = 0;
    bit [7:0] m_hold = 0;

    always @(posedge clk) begin
        bit acc;
        int len;
        if (!rst_n) begin
            line_fifo.delete();
            m_txd = 1; m_tdre = 1; m_tc = 1; m_pend = 1; m_post = 0;
        end else begin
            acc = wr_stb && m_tdre;
            len = nine_bit ? 11 : 10;
            if (!tx_en) begin
                line_fifo.delete();
                m_txd = 1; m_pend = 1; m_post = 0;
            end else if (bit_tick) begin
                if (line_fifo.size() == 0) begin
                    if (m_pend) begin
                        for (int i = 0; i < len; i++) line_fifo.push_back(1'b1);
                        m_pend = 0;
                    end else if (brk) begin
                        for (int i = 0; i < len; i++) line_fifo.push_back(1'b0);
                        m_post = 1;
                    end else if (m_post) begin
                        line_fifo.push_back(1'b1);
                        m_post = 0;
                    end else if (!m_tdre) begin
                        line_fifo.push_back(1'b0);
                        for (int i = 0; i < 8; i++) line_fifo.push_back(m_hold[i]);
                        if (nine_bit) line_fifo.push_back(ninth_bit);
                        line_fifo.push_back(1'b1);
                        m_tdre = 1;
                    end else begin
                        m_tc = 1;
                    end
                end
                if (line_fifo.size() != 0) m_txd = line_fifo.pop_front();
                else m_txd = 1;
            end
            if (acc) begin
                m_hold = wr_data; m_tdre = 0; m_tc = 0;
            end
        end
    end

    task automatic check(input string req, input bit [2:0] act, input bit [2:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d: {txd,tdre,tc} actual %b expected %b",
                     req, cyc, act, exp);
        end
    endtask

    // Drive the tick and compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        if (run_cmp) check(cur_req, {txd, tdre, tc}, {m_txd, m_tdre, m_tc});
        tick_cnt = (tick_cnt + 1) % TICKP;
        bit_tick = (tick_cnt == 0);
        if (cyc > 100000 && !done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * TICKP) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_empty();
        while (!tdre) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", {txd, tdre, tc}, 3'b111);
        run_cmp = 1'b1;

        cur_req = "R8";
        write(8'h52);
        wait_ticks(6);
        check("R8", {txd, tdre}, {1'b1, 1'b0});

        cur_req = "R9";
        tx_en = 1'b1;
        wait_ticks(11);
        cur_req = "R2";
        wait_ticks(12);
        cur_req = "R7";
        wait_ticks(3);
        check("R7", {txd, tdre, tc}, 3'b111);

        cur_req = "R4";
        write(8'hA5);
        check("R4", {1'b0, tdre, tc}, 3'b000);
        wait_empty();
        cur_req = "R6";
        write(8'h3C);
        cur_req = "R5";
        write(8'hFF);
        wait_empty();
        cur_req = "R6";
        write(8'h0F);
        wait_ticks(36);

        cur_req = "R3";
        nine_bit = 1'b1; ninth_bit = 1'b1;
        write(8'h81);
        wait_empty();
        ninth_bit = 1'b0;
        write(8'h7E);
        wait_ticks(26);
        nine_bit = 1'b0;

        cur_req = "R10";
        @(negedge clk); @(negedge clk);
        brk = 1'b1;
        write(8'h11);
        wait_ticks(33);
        cur_req = "R11";
        brk = 1'b0;
        wait_ticks(26);

        cur_req = "R8";
        write(8'hC3);
        wait_ticks(4);
        tx_en = 1'b0;
        write(8'h99);
        wait_ticks(5);
        cur_req = "R9";
        @(negedge clk);
        tx_en = 1'b1;
        wait_ticks(26);

        cur_req = "R6";
        write(8'h00);
        wait_ticks(14);
        check("R6", {txd, tdre, tc}, 3'b111);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule